// File: doc/BRIEF.md
# Ethernet Controller Control Register File

This block holds the software-visible control state of an Ethernet controller's datapath. A host reaches it through a simple register port: a 32-bit word bus with per-byte lane enables and combinational read data. The registers it holds are a command byte, a key-protected configuration lock, transmit and receive configuration words, two maximum-length fields, and the base addresses of the transmit and receive descriptor rings. Each stored value is driven straight out to the datapath.

Writing the reset bit of the command byte starts a soft reset of fixed length. During that time the block raises a reset level toward the datapath, and the reset bit reads back as set. At the end, the bit clears by itself and the session state returns to its defaults: the enables, the lock and the ring bases. The configuration values are kept. Software unlocks configuration by writing a key byte, programs the registers, and locks again. The transmit configuration word also needs transmit enabled first.

The host port carries word address bits 7:2. The byte at byte address A travels on lane A[1:0], in bits 8*A[1:0]+7 down to 8*A[1:0]. Reads return the full addressed word, and unmapped bytes read as zero.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After reset, every register reads as zero, the block is locked, and dp_rst, rx_enable and tx_enable are low.
- R2: The command byte at 0x37 (lane 3) holds receive enable in bit 3 (0x08) and transmit enable in bit 2 (0x04). A write without bit 4 updates both on the next clock, and they read back in word 0x34 bits 27 and 26.
- R3: A command write with bit 4 (0x10) set holds dp_rst high, and command bit 4 (word bit 28) reads back as 1, for exactly 16 cycles starting with the clock that takes the write. The enable bits of that same write are not applied.
- R4: When the soft reset ends, the receive and transmit enables clear, the block relocks, and both ring bases become zero. The transmit and receive configuration words and both length fields keep their values.
- R5: Command writes that arrive while the soft reset runs are ignored.
- R6: Writing 0xC0 to the byte at 0x50 unlocks the block, and that byte then reads 0xC0. Writing 0x00 locks it, and the byte reads 0x00. Any other value leaves the lock state unchanged.
- R7: While locked, writes to 0x40, 0x44, 0xDA/0xDB, 0xEC, 0x20 and 0xE4 are dropped, and reads still return the stored values.
- R8: The transmit configuration word at 0x40 takes writes only while the block is unlocked and transmit enable is set.
- R9: The receive configuration word at 0x44 is a full 32-bit register that takes writes while the block is unlocked.
- R10: The receive maximum length at 0xDA (low byte) and 0xDB (high byte) keeps only its low 14 bits, so the largest value stored is 0x3FFF. It reads back in word 0xD8 bits 29:16.
- R11: The transmit maximum length is an 8-bit register at 0xEC (lane 0).
- R12: The ring bases at 0x20 (transmit) and 0xE4 (receive) store written bits 31:8, and bits 7:0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Write strobe for one cycle |
| host_addr | input | 6 | Word address (byte address bits 7:2) |
| host_be | input | 4 | Byte lane enables for writes |
| host_wdata | input | 32 | Write data, little-endian lanes |
| host_rdata | output | 32 | Read data of the addressed word, combinational |
| dp_rst | output | 1 | Soft reset level to the datapath |
| rx_enable | output | 1 | Receive enable |
| tx_enable | output | 1 | Transmit enable |
| tx_cfg | output | 32 | Transmit configuration word |
| rx_cfg | output | 32 | Receive configuration word |
| rx_max_len | output | 14 | Receive maximum length |
| tx_max_len | output | 8 | Transmit maximum length |
| tx_ring_base | output | 32 | Transmit descriptor ring base |
| rx_ring_base | output | 32 | Receive descriptor ring base |

## Verification
The properties assume the host drives host_wr for single cycles and holds the address and data steady around the clock edge. They also assume the stored values change only through the gated write paths and the end of a soft reset, so a locked block and a disabled transmitter leave the guarded outputs frozen. The stimulus uses one access at a time, with lane enables that match the byte address of the target. It issues its only mid-reset command write well inside the 16-cycle window, and it waits for the window to close before it checks the state that the reset restores.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

  // Byte offsets of the register map
  localparam logic [7:0] OFS_CMD    = 8'h37;
  localparam logic [7:0] OFS_LOCK   = 8'h50;
  localparam logic [7:0] OFS_TXCFG  = 8'h40;
  localparam logic [7:0] OFS_RXCFG  = 8'h44;
  localparam logic [7:0] OFS_RXMAX  = 8'hDA;
  localparam logic [7:0] OFS_TXMAX  = 8'hEC;
  localparam logic [7:0] OFS_TXRING = 8'h20;
  localparam logic [7:0] OFS_RXRING = 8'hE4;

  // Byte lanes derived from the offsets
  localparam int CMD_LANE   = int'(OFS_CMD[1:0]);
  localparam int LOCK_LANE  = int'(OFS_LOCK[1:0]);
  localparam int RXMAX_LANE = int'(OFS_RXMAX[1:0]);
  localparam int TXMAX_LANE = int'(OFS_TXMAX[1:0]);

  // Command byte bit positions
  localparam int CMD_RST_BIT  = 4;
  localparam int CMD_RXEN_BIT = 3;
  localparam int CMD_TXEN_BIT = 2;

  typedef struct packed {
    logic cmd;
    logic lock;
    logic txcfg;
    logic rxcfg;
    logic rxmax;
    logic txmax;
    logic txring;
    logic rxring;
  } reg_hit_t;

endpackage

// File: rtl/nic_reg_decode.sv
module nic_reg_decode
  import nic_regs_pkg::*;
(
  input  logic [7:2] host_addr,
  output reg_hit_t   hit
);

  always_comb begin
    hit        = '0;
    hit.cmd    = (host_addr == OFS_CMD[7:2]);
    hit.lock   = (host_addr == OFS_LOCK[7:2]);
    hit.txcfg  = (host_addr == OFS_TXCFG[7:2]);
    hit.rxcfg  = (host_addr == OFS_RXCFG[7:2]);
    hit.rxmax  = (host_addr == OFS_RXMAX[7:2]);
    hit.txmax  = (host_addr == OFS_TXMAX[7:2]);
    hit.txring = (host_addr == OFS_TXRING[7:2]);
    hit.rxring = (host_addr == OFS_RXRING[7:2]);
  end

endmodule

// File: rtl/nic_reg_lanes.sv
module nic_reg_lanes #(
  parameter int          NB   = 4,
  parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NB-1:0]   be,
  input  logic [8*NB-1:0] wdata,
  input  logic            clr,
  output logic [8*NB-1:0] q
);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [7:0] lane_d;
    logic       lane_en;

    always_comb begin
      lane_en = clr | (wr & be[i]);
      lane_d  = clr ? 8'h00 : (wdata[8*i +: 8] & MASK[8*i +: 8]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[8*i +: 8] <= 8'h00;
      end else if (lane_en) begin
        q[8*i +: 8] <= lane_d;
      end
    end
  end

endmodule

// File: rtl/nic_soft_reset.sv
module nic_soft_reset #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign done = busy_q && (cnt_q == LAST);
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_regs_pkg::*;
#(
  parameter int         RST_CYCLES = 16,
  parameter int         RXMAX_W    = 14,
  parameter logic [7:0] UNLOCK_KEY = 8'hC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [7:2]         host_addr,
  input  logic [3:0]         host_be,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               dp_rst,
  output logic               rx_enable,
  output logic               tx_enable,
  output logic [31:0]        tx_cfg,
  output logic [31:0]        rx_cfg,
  output logic [RXMAX_W-1:0] rx_max_len,
  output logic [7:0]         tx_max_len,
  output logic [31:0]        tx_ring_base,
  output logic [31:0]        rx_ring_base
);

  localparam logic [31:0] RXMAX_MASK = 32'((64'd1 << RXMAX_W) - 1);
  localparam logic [31:0] RING_MASK  = 32'hFFFF_FF00;
  localparam int          RXMAX_LSB  = 8 * RXMAX_LANE;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  reg_hit_t    hit;
  logic        sr_busy, sr_done, sr_start;
  logic        cmd_wr, lock_wr;
  logic [7:0]  cmd_byte, lock_byte;
  logic        rx_q, rx_d, tx_q, tx_d, unl_q, unl_d;
  logic [15:0] rxmax_q;

  nic_reg_decode u_dec (
    .host_addr (host_addr),
    .hit       (hit)
  );

  assign cmd_byte  = host_wdata[8*CMD_LANE +: 8];
  assign lock_byte = host_wdata[8*LOCK_LANE +: 8];
  assign cmd_wr    = host_wr & hit.cmd & host_be[CMD_LANE] & ~sr_busy;
  assign lock_wr   = host_wr & hit.lock & host_be[LOCK_LANE];
  assign sr_start  = cmd_wr & cmd_byte[CMD_RST_BIT];

  nic_soft_reset #(.CYCLES(RST_CYCLES)) u_sr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (sr_start),
    .busy  (sr_busy),
    .done  (sr_done)
  );

  // Command and lock next state
  always_comb begin
    rx_d  = rx_q;
    tx_d  = tx_q;
    unl_d = unl_q;
    if (cmd_wr && !cmd_byte[CMD_RST_BIT]) begin
      rx_d = cmd_byte[CMD_RXEN_BIT];
      tx_d = cmd_byte[CMD_TXEN_BIT];
    end
    if (lock_wr) begin
      if (lock_byte == UNLOCK_KEY)  unl_d = 1'b1;
      else if (lock_byte == 8'h00)  unl_d = 1'b0;
    end
    if (sr_done) begin
      rx_d  = 1'b0;
      tx_d  = 1'b0;
      unl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
      unl_q <= 1'b0;
    end else begin
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      unl_q <= unl_d;
    end
  end

  // Protected configuration storage
  nic_reg_lanes #(.NB(4)) u_txcfg (
    .clk (clk), .rst_n (rst_sync_n),
    .wr  (host_wr & hit.txcfg & unl_q & tx_q),
    .be  (host_be), .wdata (host_wdata), .clr (1'b0), .q (tx_cfg)
  );

  nic_reg_lanes #(.NB(4)) u_rxcfg (
    .clk (clk), .rst_n (rst_sync_n),
    .wr  (host_wr & hit.rxcfg & unl_q),
    .be  (host_be), .wdata (host_wdata), .clr (1'b0), .q (rx_cfg)
  );

  nic_reg_lanes #(.NB(2), .MASK(RXMAX_MASK)) u_rxmax (
    .clk (clk), .rst_n (rst_sync_n),
    .wr  (host_wr & hit.rxmax & unl_q),
    .be  (host_be[RXMAX_LANE +: 2]), .wdata (host_wdata[RXMAX_LSB +: 16]),
    .clr (1'b0), .q (rxmax_q)
  );

  nic_reg_lanes #(.NB(1)) u_txmax (
    .clk (clk), .rst_n (rst_sync_n),
    .wr  (host_wr & hit.txmax & unl_q),
    .be  (host_be[TXMAX_LANE]), .wdata (host_wdata[8*TXMAX_LANE +: 8]),
    .clr (1'b0), .q (tx_max_len)
  );

  nic_reg_lanes #(.NB(4), .MASK(RING_MASK)) u_txring (
    .clk (clk), .rst_n (rst_sync_n),
    .wr  (host_wr & hit.txring & unl_q),
    .be  (host_be), .wdata (host_wdata), .clr (sr_done), .q (tx_ring_base)
  );

  nic_reg_lanes #(.NB(4), .MASK(RING_MASK)) u_rxring (
    .clk (clk), .rst_n (rst_sync_n),
    .wr  (host_wr & hit.rxring & unl_q),
    .be  (host_be), .wdata (host_wdata), .clr (sr_done), .q (rx_ring_base)
  );

  assign rx_max_len = rxmax_q[RXMAX_W-1:0];
  assign dp_rst     = sr_busy;
  assign rx_enable  = rx_q;
  assign tx_enable  = tx_q;

  // Read mux
  always_comb begin
    host_rdata = '0;
    if (hit.cmd) begin
      host_rdata[8*CMD_LANE + CMD_RST_BIT]  = sr_busy;
      host_rdata[8*CMD_LANE + CMD_RXEN_BIT] = rx_q;
      host_rdata[8*CMD_LANE + CMD_TXEN_BIT] = tx_q;
    end
    if (hit.lock)   host_rdata[8*LOCK_LANE +: 8]  = unl_q ? UNLOCK_KEY : 8'h00;
    if (hit.txcfg)  host_rdata = tx_cfg;
    if (hit.rxcfg)  host_rdata = rx_cfg;
    if (hit.rxmax)  host_rdata[RXMAX_LSB +: 16]    = rxmax_q;
    if (hit.txmax)  host_rdata[8*TXMAX_LANE +: 8] = tx_max_len;
    if (hit.txring) host_rdata = tx_ring_base;
    if (hit.rxring) host_rdata = rx_ring_base;
  end

endmodule

// File: rtl/nic_ctrl_regs_chk.sv
module nic_ctrl_regs_chk #(
  parameter int RST_CYCLES = 16,
  parameter int RXMAX_W    = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dp_rst,
  input logic               rx_enable,
  input logic               tx_enable,
  input logic               unlocked,
  input logic [31:0]        tx_cfg,
  input logic [31:0]        rx_cfg,
  input logic [RXMAX_W-1:0] rx_max_len,
  input logic [7:0]         tx_max_len,
  input logic [31:0]        tx_ring_base,
  input logic [31:0]        rx_ring_base
);

  localparam int CW = $clog2(RST_CYCLES) + 2;
  localparam logic [CW-1:0] LIM = CW'(RST_CYCLES);

  // Cycles dp_rst has been high before the current one
  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (dp_rst) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  p_rst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst |-> (hi_cnt < LIM));

  p_rst_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_rst) |-> (hi_cnt == LIM));

  p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_rst) |-> (!rx_enable && !tx_enable && !unlocked &&
                       tx_ring_base == 32'h0 && rx_ring_base == 32'h0));

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst |=> (!dp_rst || ($stable(rx_enable) && $stable(tx_enable))));

  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(rx_cfg) && $stable(tx_cfg) &&
                   $stable(tx_max_len) && $stable(rx_max_len)));

  p_txcfg_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> $stable(tx_cfg));

  p_ring_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ring_base[7:0] == 8'h00) && (rx_ring_base[7:0] == 8'h00));

endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk #(
  .RST_CYCLES (RST_CYCLES),
  .RXMAX_W    (RXMAX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .dp_rst       (dp_rst),
  .rx_enable    (rx_enable),
  .tx_enable    (tx_enable),
  .unlocked     (unl_q),
  .tx_cfg       (tx_cfg),
  .rx_cfg       (rx_cfg),
  .rx_max_len   (rx_max_len),
  .tx_max_len   (tx_max_len),
  .tx_ring_base (tx_ring_base),
  .rx_ring_base (rx_ring_base)
);

// File: tb/nic_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module nic_ctrl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [7:2]  host_addr;
  logic [3:0]  host_be;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        dp_rst, rx_enable, tx_enable;
  logic [31:0] tx_cfg, rx_cfg, tx_ring_base, rx_ring_base;
  logic [13:0] rx_max_len;
  logic [7:0]  tx_max_len;

  int checks   = 0;
  int failures = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  nic_ctrl_regs dut_i (
    .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_addr (host_addr),
    .host_be (host_be), .host_wdata (host_wdata), .host_rdata (host_rdata),
    .dp_rst (dp_rst), .rx_enable (rx_enable), .tx_enable (tx_enable),
    .tx_cfg (tx_cfg), .rx_cfg (rx_cfg), .rx_max_len (rx_max_len),
    .tx_max_len (tx_max_len), .tx_ring_base (tx_ring_base),
    .rx_ring_base (rx_ring_base)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read words and compares them
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk($sformatf("%s @%h", it.tag, it.addr), host_rdata, it.exp);
      end
    end
  end

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    host_wr   = 1'b0;
    host_addr = a[7:2];
    it.addr = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr_acc(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a[7:2]; host_be = be; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0; host_be = 4'h0;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    wr_acc(a, {24'h0, d} << (8 * a[1:0]), 4'b0001 << a[1:0]);
  endtask

  task automatic wr_half(input logic [7:0] a, input logic [15:0] d);
    wr_acc(a, {16'h0, d} << (8 * a[1:0]), 4'b0011 << a[1:0]);
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
    wr_acc(a, d, 4'hF);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_be = '0; host_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd_expect(8'h34, 32'h0, "R1 cmd");
    rd_expect(8'h50, 32'h0, "R1 lock");
    @(negedge clk);
    chk("R1 dp_rst", {31'h0, dp_rst}, 32'h0);
    chk("R1 enables", {30'h0, rx_enable, tx_enable}, 32'h0);

    // R7 writes dropped while locked
    wr_word(8'h44, 32'h0000_E70F);
    rd_expect(8'h44, 32'h0, "R7 rxcfg locked");
    wr_half(8'hDA, 16'h1FFF);
    rd_expect(8'hD8, 32'h0, "R7 rxmax locked");

    // R6 lock key
    wr_byte(8'h50, 8'h55);
    rd_expect(8'h50, 32'h0, "R6 bad key");
    wr_byte(8'h50, 8'hC0);
    rd_expect(8'h50, 32'h0000_00C0, "R6 unlock");
    wr_byte(8'h50, 8'h12);
    rd_expect(8'h50, 32'h0000_00C0, "R6 other value");

    // R9 receive config
    wr_word(8'h44, 32'h0000_E70F);
    rd_expect(8'h44, 32'h0000_E70F, "R9 rxcfg");

    // R8 transmit config gated by tx enable
    wr_word(8'h40, 32'h0300_0700);
    rd_expect(8'h40, 32'h0, "R8 txcfg tx off");
    wr_byte(8'h37, 8'h04);
    rd_expect(8'h34, 32'h0400_0000, "R2 tx on");
    @(negedge clk);
    chk("R2 tx_enable", {31'h0, tx_enable}, 32'h1);
    wr_word(8'h40, 32'h0300_0700);
    rd_expect(8'h40, 32'h0300_0700, "R8 txcfg tx on");

    // R10 receive max length
    wr_half(8'hDA, 16'hFFFF);
    rd_expect(8'hD8, 32'h3FFF_0000, "R10 rxmax clip");
    @(negedge clk);
    chk("R10 rx_max_len", {18'h0, rx_max_len}, 32'h3FFF);
    wr_half(8'hDA, 16'h1FFF);
    rd_expect(8'hD8, 32'h1FFF_0000, "R10 rxmax");

    // R11 transmit max length
    wr_byte(8'hEC, 8'h3B);
    rd_expect(8'hEC, 32'h0000_003B, "R11 txmax");

    // R12 ring bases
    wr_word(8'h20, 32'h0010_00FF);
    rd_expect(8'h20, 32'h0010_0000, "R12 txring");
    wr_word(8'hE4, 32'h1234_5678);
    rd_expect(8'hE4, 32'h1234_5600, "R12 rxring");
    @(negedge clk);
    chk("R12 tx_ring_base", tx_ring_base, 32'h0010_0000);

    // R2 both enables
    wr_byte(8'h37, 8'h0C);
    rd_expect(8'h34, 32'h0C00_0000, "R2 rx+tx");

    // R7 relock and dropped writes
    wr_byte(8'h50, 8'h00);
    rd_expect(8'h50, 32'h0, "R6 relock");
    wr_word(8'h44, 32'h0000_DEAD);
    rd_expect(8'h44, 32'h0000_E70F, "R7 rxcfg kept");
    wr_byte(8'hEC, 8'h11);
    rd_expect(8'hEC, 32'h0000_003B, "R7 txmax kept");
    wr_word(8'h20, 32'hAAAA_AA00);
    rd_expect(8'h20, 32'h0010_0000, "R7 txring kept");
    wr_byte(8'h37, 8'h00);
    wr_word(8'h40, 32'h5555_5555);
    rd_expect(8'h40, 32'h0300_0700, "R7 txcfg kept");
    wr_byte(8'h37, 8'h0C);

    // R3 soft reset window, unlocked first so relock is visible
    wr_byte(8'h50, 8'hC0);
    wr_byte(8'h37, 8'h10);
    host_addr = 6'(8'h34 >> 2);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      chk($sformatf("R3 dp_rst cycle %0d", k), {31'h0, dp_rst}, 32'h1);
      chk($sformatf("R3 rst bit cycle %0d", k), {31'h0, host_rdata[28]}, 32'h1);
    end
    @(negedge clk);
    chk("R3 dp_rst end", {31'h0, dp_rst}, 32'h0);
    chk("R3 rst bit end", {31'h0, host_rdata[28]}, 32'h0);

    // R4 restored defaults and kept configuration
    rd_expect(8'h34, 32'h0, "R4 enables cleared");
    rd_expect(8'h50, 32'h0, "R4 relocked");
    rd_expect(8'h20, 32'h0, "R4 txring cleared");
    rd_expect(8'hE4, 32'h0, "R4 rxring cleared");
    rd_expect(8'h44, 32'h0000_E70F, "R4 rxcfg kept");
    rd_expect(8'h40, 32'h0300_0700, "R4 txcfg kept");
    rd_expect(8'hD8, 32'h1FFF_0000, "R4 rxmax kept");
    rd_expect(8'hEC, 32'h0000_003B, "R4 txmax kept");

    // R5 command writes ignored during soft reset
    wr_byte(8'h37, 8'h08);
    wr_byte(8'h37, 8'h10);
    wr_byte(8'h37, 8'h04);
    rd_expect(8'h34, 32'h1800_0000, "R5 write ignored");
    repeat (20) @(posedge clk);
    rd_expect(8'h34, 32'h0, "R5 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule